// File: doc/BRIEF.md
# Radio Bit Serializer with Edge-Aligned Receive Timing

This block does all per-bit timing for a raw on/off-keyed radio data pin, so the processor next to it only ever moves whole bytes. On the transmit side the processor writes a byte into a one-byte holding register. The block moves that byte into a shift register and drives its bits onto the line, least-significant bit first. Each bit lasts a fixed number of clock cycles: 80 cycles by default, which gives 50 kb/s from a 4 MHz clock. A byte written while the previous one is still shifting follows it with no idle gap.

On the receive side an external start-symbol detector pulses a start input. The block then waits for the next transition on the receive pin. That transition marks the start of the first data bit. The block records the value of a free-running 16-bit cycle counter at that moment and resets its bit-phase counter there. Each bit is then sampled at the middle of its period. The block assembles the sampled bits into bytes, least-significant bit first, and presents each byte with a one-cycle strobe and a full flag that stays up until the processor acknowledges the byte.

Top module: `radio_bit_engine`

## Requirements
- R1: After a byte is accepted into the holding register, its bit 0 appears on `tx_line` one clock later. Each bit is held for 80 clocks, bits go out LSB first, and `tx_line` is 0 whenever no byte is shifting.
- R2: `tx_ready` is 1 exactly when the holding register is empty. `tx_wr` loads `tx_data` only while `tx_ready` is 1. A write while `tx_ready` is 0 is ignored and that data never reaches the line.
- R3: A byte waiting in the holding register starts on the clock right after the last bit of the current byte ends, so the bit stream has no gap between bytes.
- R4: Transitions on `rx_line` have no effect until a `rx_start` pulse has been seen. After that pulse, the first transition aligns reception, and each bit is sampled 40 clocks after its aligned bit boundary, LSB first.
- R5: When a byte completes, `rx_data` takes the byte, `rx_strobe` is high for exactly one clock, and `rx_full` is set. `rx_full` stays set until `rx_rd` is high on a clock edge with no new completion on that edge.
- R6: Once aligned, reception continues with successive bytes every 640 clocks, with no further transition needed, until the next `rx_start` pulse.
- R7: `rx_overrun` is set when a byte completes while `rx_full` is set and `rx_rd` is low. `rx_data` then holds the newest byte. `rx_rd` clears `rx_overrun`.
- R8: At each aligning transition, `edge_stamp` captures the free-running 16-bit cycle count. The difference between two captured stamps equals the number of clocks between the two aligning transitions, modulo 2^16. Data transitions after alignment leave the stamp unchanged.
- R9: After reset, `tx_ready`=1, `tx_line`=0, `rx_strobe`=0, `rx_full`=0, `rx_overrun`=0 and `edge_stamp`=0.
- R10: A `rx_start` pulse during reception drops the partly assembled byte without delivering it. The block then re-aligns on the next transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock (4 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Write strobe for `tx_data` |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_line | output | 1 | Serial data to the radio transmitter |
| rx_line | input | 1 | Digitised data from the radio receiver |
| rx_start | input | 1 | One-cycle start-symbol-detected pulse |
| rx_data | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse when a byte completes |
| rx_full | output | 1 | Received byte not yet acknowledged |
| rx_rd | input | 1 | Acknowledge of `rx_data` |
| rx_overrun | output | 1 | A byte was overwritten before acknowledge |
| edge_stamp | output | 16 | Cycle count captured at the last aligning transition |

## Verification
Every receive error comes from the bit-phase counter or the bit index. If the phase counter is off, the sample point moves into a neighbouring bit, and `rx_data` shows shifted or doubled bits within one byte time, about 640 clocks. If the bit index is wrong, the strobe arrives at the wrong moment or bytes are lost, which the scoreboard flags as a missing byte or an unexpected one. On transmit, a wrong phase or index changes the line value at a fixed mid-bit sample point within one bit period. A wrongly cleared holding flag shows up as a repeated byte or a dropped byte at the next byte boundary.

// File: rtl/radio_bit_pkg.sv
package radio_bit_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HUNT = 2'd1,
    RX_BITS = 2'd2
  } rx_state_e;

endpackage

// File: rtl/rbs_reset_sync.sv
module rbs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/rbs_cycle_count.sv
module rbs_cycle_count #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] count_o
);

  logic [TS_W-1:0] cnt_q;
  logic [TS_W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + TS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/rbs_tx.sv
module rbs_tx #(
  parameter int BIT_CYCLES = 80,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wr_i,
  output logic              ready_o,
  output logic              line_o
);

  localparam int PH_W  = $clog2(BIT_CYCLES);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] hold_q, sh_q, sh_d;
  logic              full_q, full_d, busy_q, busy_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              accept, bit_end, last_bit, load;

  always_comb begin
    accept   = wr_i && !full_q;
    bit_end  = busy_q && (ph_q == PH_W'(BIT_CYCLES - 1));
    last_bit = bit_end && (idx_q == IDX_W'(DATA_W - 1));
    load     = full_q && (!busy_q || last_bit);

    full_d = full_q;
    if (accept)    full_d = 1'b1;
    else if (load) full_d = 1'b0;

    sh_d   = sh_q;
    busy_d = busy_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    if (load) begin
      sh_d   = hold_q;
      busy_d = 1'b1;
      ph_d   = '0;
      idx_d  = '0;
    end else if (last_bit) begin
      busy_d = 1'b0;
      ph_d   = '0;
      idx_d  = '0;
    end else if (bit_end) begin
      sh_d  = {1'b0, sh_q[DATA_W-1:1]};
      ph_d  = '0;
      idx_d = idx_q + IDX_W'(1);
    end else if (busy_q) begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '0;
      busy_q <= 1'b0;
      ph_q   <= '0;
      idx_q  <= '0;
    end else begin
      if (accept) hold_q <= data_i;
      full_q <= full_d;
      sh_q   <= sh_d;
      busy_q <= busy_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
    end
  end

  assign ready_o = !full_q;
  assign line_o  = busy_q & sh_q[0];

endmodule

// File: rtl/rbs_rx.sv
module rbs_rx
  import radio_bit_pkg::*;
#(
  parameter int BIT_CYCLES = 80,
  parameter int SAMPLE_OFS = 40,
  parameter int DATA_W     = 8,
  parameter int TS_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [TS_W-1:0]   stamp_i,
  output logic [DATA_W-1:0] data_o,
  output logic              strobe_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic [TS_W-1:0]   edge_ts_o
);

  localparam int PH_W  = $clog2(BIT_CYCLES);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         st_q, st_d;
  logic              line_q;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d, data_q;
  logic              strobe_q, full_q, full_d, ovr_q, ovr_d;
  logic [TS_W-1:0]   ts_q;
  logic              edge_seen, align, sample, done;

  always_comb begin
    edge_seen = line_i ^ line_q;
    align     = (st_q == RX_HUNT) && edge_seen && !start_i;
    sample    = (st_q == RX_BITS) && !start_i && (ph_q == PH_W'(SAMPLE_OFS - 1));
    done      = sample && (idx_q == IDX_W'(DATA_W - 1));

    st_d  = st_q;
    ph_d  = ph_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    if (start_i) begin
      st_d = RX_HUNT;
    end else if (align) begin
      st_d  = RX_BITS;
      ph_d  = '0;
      idx_d = '0;
    end else if (st_q == RX_BITS) begin
      ph_d = (ph_q == PH_W'(BIT_CYCLES - 1)) ? '0 : ph_q + PH_W'(1);
      if (sample) begin
        sh_d  = {line_i, sh_q[DATA_W-1:1]};
        idx_d = done ? '0 : idx_q + IDX_W'(1);
      end
    end

    full_d = full_q;
    ovr_d  = ovr_q;
    if (done) begin
      full_d = 1'b1;
      ovr_d  = !rd_i && (full_q || ovr_q);
    end else if (rd_i) begin
      full_d = 1'b0;
      ovr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RX_IDLE;
      line_q   <= 1'b0;
      ph_q     <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      data_q   <= '0;
      strobe_q <= 1'b0;
      full_q   <= 1'b0;
      ovr_q    <= 1'b0;
      ts_q     <= '0;
    end else begin
      st_q     <= st_d;
      line_q   <= line_i;
      ph_q     <= ph_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      strobe_q <= done;
      full_q   <= full_d;
      ovr_q    <= ovr_d;
      if (done)  data_q <= sh_d;
      if (align) ts_q   <= stamp_i;
    end
  end

  assign data_o    = data_q;
  assign strobe_o  = strobe_q;
  assign full_o    = full_q;
  assign ovr_o     = ovr_q;
  assign edge_ts_o = ts_q;

endmodule

// File: rtl/radio_bit_engine.sv
module radio_bit_engine #(
  parameter int BIT_CYCLES = 80,
  parameter int SAMPLE_OFS = 40,
  parameter int DATA_W     = 8,
  parameter int TS_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic              tx_ready,
  output logic              tx_line,
  input  logic              rx_line,
  input  logic              rx_start,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_strobe,
  output logic              rx_full,
  input  logic              rx_rd,
  output logic              rx_overrun,
  output logic [TS_W-1:0]   edge_stamp
);

  logic            rst_sn;
  logic [TS_W-1:0] cycle_now;

  rbs_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  rbs_cycle_count #(.TS_W(TS_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sn),
    .count_o (cycle_now)
  );

  rbs_tx #(.BIT_CYCLES(BIT_CYCLES), .DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_sn),
    .data_i  (tx_data),
    .wr_i    (tx_wr),
    .ready_o (tx_ready),
    .line_o  (tx_line)
  );

  rbs_rx #(
    .BIT_CYCLES (BIT_CYCLES),
    .SAMPLE_OFS (SAMPLE_OFS),
    .DATA_W     (DATA_W),
    .TS_W       (TS_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_sn),
    .line_i    (rx_line),
    .start_i   (rx_start),
    .rd_i      (rx_rd),
    .stamp_i   (cycle_now),
    .data_o    (rx_data),
    .strobe_o  (rx_strobe),
    .full_o    (rx_full),
    .ovr_o     (rx_overrun),
    .edge_ts_o (edge_stamp)
  );

endmodule

// File: rtl/radio_bit_engine_chk.sv
module radio_bit_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_wr,
  input logic tx_ready,
  input logic rx_strobe,
  input logic rx_full,
  input logic rx_rd,
  input logic rx_overrun
);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  // R5
  strobe_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> rx_full);

  // R5
  read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |=> (!rx_full || rx_strobe));

  // R7
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_full);

  // R7
  overrun_on_completion_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overrun) |-> rx_strobe);

  // R2
  write_takes_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && tx_wr) |=> !tx_ready);

endmodule

bind radio_bit_engine radio_bit_engine_chk u_chk (.*);

// File: tb/test_radio_bit_engine.sv
module test_radio_bit_engine;

  localparam int CLK_PERIOD = 10;
  localparam int BITP       = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_wr = 1'b0;
  logic        tx_ready, tx_line;
  logic        rx_line = 1'b0;
  logic        rx_start = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_strobe, rx_full, rx_overrun;
  logic        rx_rd;
  logic        mon_rd = 1'b0;
  logic        man_rd = 1'b0;
  logic [15:0] edge_stamp;

  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  int          strobes = 0;
  bit          auto_rd = 1'b1;
  bit          finished = 1'b0;
  logic [7:0]  exp_tx[$];
  logic [7:0]  exp_rx[$];

  assign rx_rd = mon_rd | man_rd;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  radio_bit_engine i_radio_bit_engine (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_wr(tx_wr),
    .tx_ready(tx_ready), .tx_line(tx_line), .rx_line(rx_line),
    .rx_start(rx_start), .rx_data(rx_data), .rx_strobe(rx_strobe),
    .rx_full(rx_full), .rx_rd(rx_rd), .rx_overrun(rx_overrun),
    .edge_stamp(edge_stamp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // receive monitor: pops expected bytes on each strobe
  initial begin
    forever begin
      @(negedge clk);
      mon_rd = 1'b0;
      if (rx_strobe) begin
        strobes++;
        if (exp_rx.size() == 0) begin
          check(1'b0, "R4/R10 unexpected byte", rx_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R4/R6 received byte", rx_data, e);
        end
        if (auto_rd) mon_rd = 1'b1;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    wrap_up();
  end

  // transmit driver (R2) and monitor (R1, R3)
  task automatic tx_stream(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    fork
      begin
        for (int i = 0; i < 3; i++) begin
          while (!tx_ready) @(negedge clk);
          tx_data = bytes[i];
          tx_wr = 1'b1;
          exp_tx.push_back(bytes[i]);
          @(negedge clk);
          if (i == 0) begin
            check(!tx_ready, "R2 ready drops after write", tx_ready, 0);
            tx_data = 8'hFF;   // R2: ignored write while holding register full
          end else begin
            tx_wr = 1'b0;
          end
          if (i == 0) begin
            @(negedge clk);
            tx_wr = 1'b0;
          end
        end
      end
      begin
        repeat (42) @(posedge clk);
        @(negedge clk);
        for (int j = 0; j < 3; j++) begin
          logic [7:0] got;
          logic [7:0] e;
          for (int k = 0; k < 8; k++) begin
            got[k] = tx_line;
            repeat (BITP) @(posedge clk);
            @(negedge clk);
          end
          e = exp_tx.pop_front();
          check(got == e, "R1/R3 transmitted byte", got, e);
        end
        check(tx_line == 1'b0, "R1 line idle after stream", tx_line, 0);
        check(tx_ready == 1'b1, "R2 ready when idle", tx_ready, 1);
      end
    join
  endtask

  task automatic pulse_start();
    rx_start = 1'b1;
    @(negedge clk);
    rx_start = 1'b0;
  endtask

  // receive stimulus: nb bytes a, b after an aligning transition
  task automatic rx_packet(input logic [7:0] a, input logic [7:0] b, input int nb,
                           output int ecyc, output logic [15:0] ts);
    @(negedge clk);
    rx_line = ~a[0];
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    exp_rx.push_back(a);
    if (nb > 1) exp_rx.push_back(b);
    ecyc = cyc + 1;
    ts = '0;
    for (int k = 0; k < nb; k++) begin
      logic [7:0] cur;
      cur = (k == 0) ? a : b;
      for (int i = 0; i < 8; i++) begin
        rx_line = cur[i];
        if (k == 0 && i == 0) begin
          @(negedge clk);
          ts = edge_stamp;
          repeat (BITP - 1) @(negedge clk);
        end else begin
          repeat (BITP) @(negedge clk);
        end
      end
    end
    check(edge_stamp == ts, "R8 stamp unchanged by data edges", edge_stamp, ts);
    pulse_start();
  endtask

  initial begin
    int          e1, e2, e3;
    logic [15:0] t1, t2, t3;
    int          s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    check(tx_ready == 1'b1, "R9 tx_ready", tx_ready, 1);
    check(tx_line == 1'b0, "R9 tx_line", tx_line, 0);
    check(rx_strobe == 1'b0, "R9 rx_strobe", rx_strobe, 0);
    check(rx_full == 1'b0, "R9 rx_full", rx_full, 0);
    check(rx_overrun == 1'b0, "R9 rx_overrun", rx_overrun, 0);
    check(edge_stamp == 16'h0, "R9 edge_stamp", edge_stamp, 0);

    // R4: transitions before any start pulse are ignored
    s0 = strobes;
    for (int i = 0; i < 12; i++) begin
      rx_line = ~rx_line;
      repeat (57) @(negedge clk);
    end
    repeat (700) @(negedge clk);
    check(strobes == s0, "R4 no reception before start", strobes, s0);
    check(edge_stamp == 16'h0, "R4 stamp untouched before start", edge_stamp, 0);
    check(rx_full == 1'b0, "R4 nothing buffered before start", rx_full, 0);

    // R1, R2, R3 transmit stream
    tx_stream(8'hA5, 8'h3C, 8'h81);
    tx_stream(8'h00, 8'hFF, 8'h5A);

    // R4, R5, R6, R8 receive with acknowledge
    auto_rd = 1'b1;
    rx_packet(8'hC3, 8'h1E, 2, e1, t1);
    repeat (5) @(negedge clk);
    check(rx_full == 1'b0, "R5 full cleared by read", rx_full, 0);
    check(rx_overrun == 1'b0, "R7 no overrun when read in time", rx_overrun, 0);
    rx_packet(8'h01, 8'h80, 2, e2, t2);
    check(16'(t2 - t1) == 16'(e2 - e1), "R8 stamp difference", 16'(t2 - t1), 16'(e2 - e1));

    // R10: restart mid-byte drops partial byte
    @(negedge clk);
    rx_line = 1'b1;
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    rx_line = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rx_line = i[0];
      repeat (BITP) @(negedge clk);
    end
    s0 = strobes;
    rx_packet(8'h6B, 8'h00, 1, e3, t3);
    check(strobes == s0 + 1, "R10 only the realigned byte delivered", strobes, s0 + 1);
    check(16'(t3 - t2) == 16'(e3 - e2), "R10 realigned stamp", 16'(t3 - t2), 16'(e3 - e2));

    // R7 overrun without acknowledge
    repeat (5) @(negedge clk);
    auto_rd = 1'b0;
    rx_packet(8'h96, 8'h4D, 2, e1, t1);
    repeat (2) @(negedge clk);
    check(rx_full == 1'b1, "R7 full held without read", rx_full, 1);
    check(rx_overrun == 1'b1, "R7 overrun set", rx_overrun, 1);
    check(rx_data == 8'h4D, "R7 newest byte kept", rx_data, 8'h4D);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    @(negedge clk);
    check(rx_full == 1'b0, "R5 read clears full", rx_full, 0);
    check(rx_overrun == 1'b0, "R7 read clears overrun", rx_overrun, 0);
    check(exp_rx.size() == 0, "R6 all expected bytes delivered", exp_rx.size(), 0);

    wrap_up();
  end

endmodule